// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Character Queue

This block turns an asynchronous serial line into parallel characters. It samples the line on a clock enable that pulses sixteen times per bit period. It checks each start bit at its centre, then gathers 5 to 8 data bits least significant bit first. When parity is enabled it also captures a parity bit, and it then samples the first stop bit. Word length, parity enable, parity sense and the number of stop bits are run-time inputs.

Each finished character goes into storage with three flags: parity error, framing error and break. In queue mode the storage holds up to sixteen characters. Out of reset, queue mode is off and the storage acts as one holding register. The host sees the character at the head of the storage together with its flags, and a data-ready indication. A one-cycle read strobe removes the head character. A character that finishes while the storage is full is dropped, and a sticky overrun flag is raised. A status-read pulse clears that flag.

Top module: `sio_rx`

## Requirements
- R1: `wlen_sel` picks the data bits per character: 00 = 5, 01 = 6, 10 = 7, 11 = 8. Bits arrive least significant first, and read-data bits above the word length read as zero.
- R2: With `par_en` high, one parity bit follows the data. When `par_even` is 1, the data bits plus the parity bit must hold an even number of ones; when it is 0, an odd number. A mismatch sets `rd_perr` for that character. With `par_en` low, no parity bit is expected and `rd_perr` is 0.
- R3: A low level starts a character only if the line is still low at the eighth sample tick. A shorter low pulse produces no character.
- R4: A first stop bit sampled low sets `rd_ferr` on that character. After such a character the receiver waits for the line to return high before it looks for a new start bit. When `stop_two` is 1, the second stop bit is not checked.
- R5: When the start bit, the data bits, the parity bit (if enabled) and the stop bit all sample low, one character is stored with data 0, `rd_brk` = 1 and `rd_ferr` = 1. However long the line stays low, no further character is stored until it returns high.
- R6: With `fifo_on` high, up to 16 characters are kept and read back in arrival order, each with its own flags.
- R7: With `fifo_on` low (the reset setting), only one character is kept.
- R8: A character that completes while storage is full is discarded and `overrun` goes high. `overrun` stays high until a `status_rd` pulse. If both happen in the same cycle, setting wins.
- R9: `data_rdy` is high exactly while at least one character is stored. `rd_data`, `rd_perr`, `rd_ferr` and `rd_brk` show the head character, and all read 0 when storage is empty.
- R10: A `fifo_clr` pulse empties the storage in the next cycle.
- R11: `rd_strobe` while storage is empty changes nothing.
- R12: After reset, `data_rdy`, `overrun` and all read outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_in | input | 1 | Serial line, idle high, synchronised inside |
| tick16 | input | 1 | Sample enable, sixteen pulses per bit |
| wlen_sel | input | 2 | Word length code (R1) |
| par_en | input | 1 | Parity bit present |
| par_even | input | 1 | 1 = even parity, 0 = odd |
| stop_two | input | 1 | Two stop bits in use |
| fifo_on | input | 1 | 1 = sixteen-entry queue, 0 = single register |
| rd_strobe | input | 1 | Remove head character |
| status_rd | input | 1 | Clears the overrun flag |
| fifo_clr | input | 1 | Empties storage |
| rd_data | output | 8 | Head character data |
| rd_perr | output | 1 | Head character parity error |
| rd_ferr | output | 1 | Head character framing error |
| rd_brk | output | 1 | Head character is a break |
| data_rdy | output | 1 | At least one character stored |
| overrun | output | 1 | Sticky overrun indication |

## Verification
The bench sends a long low break and expects exactly one zero character with break and framing set. A receiver that resumed hunting at once would store a stream of break characters. A short low glitch must produce nothing; a receiver that trusts the first low sample would store a 0xFF-like garbage character. Overrun is forced in both storage modes. Dropping the wrong character, overwriting the head, or clearing the flag without a status read would show up as wrong data or a wrong flag. Random frames mix every word length, both parity senses and deliberate parity and stop-bit faults, so a parity sense or bit-order mistake shows up at once in the data or the flags.

// File: rtl/sio_rx_pkg.sv
package sio_rx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_GAP,
        ST_MARK
    } rx_state_e;

    typedef struct packed {
        logic       brk;
        logic       ferr;
        logic       perr;
        logic [7:0] data;
    } rx_char_t;

    localparam int CHAR_W = $bits(rx_char_t);

    function automatic logic [2:0] last_bit_idx(input logic [1:0] sel);
        return {1'b0, sel} + 3'd4;
    endfunction

endpackage

// File: rtl/sio_rx_sync.sv
module sio_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic d_out
);
    logic [STAGES-1:0] chain_q, chain_d;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], d_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign d_out = chain_q[STAGES-1];
endmodule

// File: rtl/sio_rx_frame.sv
module sio_rx_frame
    import sio_rx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx,
    input  logic       tick,
    input  logic [1:0] wlen_sel,
    input  logic       par_en,
    input  logic       par_even,
    input  logic       stop_two,
    output logic       push,
    output rx_char_t   chr
);
    localparam int CW = $clog2(OVS);
    localparam logic [CW-1:0] LAST_TICK  = CW'(OVS - 1);
    localparam logic [CW-1:0] START_TICK = CW'(OVS / 2 - 2);
    localparam logic [CW-1:0] GAP_TICK   = CW'(OVS / 2 - 1);

    typedef struct packed {
        rx_state_e   st;
        logic [CW-1:0] cnt;
        logic [2:0]  idx;
        logic [7:0]  shreg;
        logic        pbit;
        logic        push;
        rx_char_t    chr;
    } frame_t;

    frame_t q, d;

    always_comb begin
        d      = q;
        d.push = 1'b0;
        if (tick) begin
            unique case (q.st)
                ST_IDLE: begin
                    if (!rx) begin
                        d.st  = ST_START;
                        d.cnt = '0;
                    end
                end
                ST_START: begin
                    if (q.cnt == START_TICK) begin
                        d.cnt   = '0;
                        d.idx   = '0;
                        d.shreg = '0;
                        d.pbit  = 1'b0;
                        d.st    = rx ? ST_IDLE : ST_DATA;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                ST_DATA: begin
                    if (q.cnt == LAST_TICK) begin
                        d.cnt          = '0;
                        d.shreg[q.idx] = rx;
                        if (q.idx == last_bit_idx(wlen_sel)) begin
                            d.st = par_en ? ST_PAR : ST_STOP;
                        end else begin
                            d.idx = q.idx + 1'b1;
                        end
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                ST_PAR: begin
                    if (q.cnt == LAST_TICK) begin
                        d.cnt  = '0;
                        d.pbit = rx;
                        d.st   = ST_STOP;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                ST_STOP: begin
                    if (q.cnt == LAST_TICK) begin
                        d.cnt      = '0;
                        d.push     = 1'b1;
                        d.chr.data = q.shreg;
                        d.chr.perr = par_en & ((^q.shreg) ^ q.pbit ^ ~par_even);
                        d.chr.ferr = ~rx;
                        d.chr.brk  = ~rx & (q.shreg == 8'd0) & ~(par_en & q.pbit);
                        if (!rx)           d.st = ST_MARK;
                        else if (stop_two) d.st = ST_GAP;
                        else               d.st = ST_IDLE;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                ST_GAP: begin
                    if (q.cnt == GAP_TICK) begin
                        d.cnt = '0;
                        d.st  = ST_IDLE;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                ST_MARK: begin
                    if (rx) d.st = ST_IDLE;
                end
                default: d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_IDLE, default: '0};
        else        q <= d;
    end

    assign push = q.push;
    assign chr  = q.chr;

    // R5: a break character always carries a framing error and zero data
    a_r5_brk_shape: assert property (@(posedge clk) disable iff (!rst_n)
        (q.push && q.chr.brk) |-> (q.chr.ferr && q.chr.data == 8'd0));

    // R3: one character never yields more than a single push cycle
    a_r3_push_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        q.push |=> !q.push);

    // R1: five-bit words never fill the upper data bits
    a_r1_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (q.push && $stable(wlen_sel) && wlen_sel == 2'b00) |-> (q.chr.data[7:5] == 3'd0));

endmodule

// File: rtl/sio_rx_fifo.sv
module sio_rx_fifo
    import sio_rx_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     fifo_on,
    input  logic     push,
    input  rx_char_t wdata,
    input  logic     pop_req,
    input  logic     status_rd,
    input  logic     clr,
    output rx_char_t head,
    output logic     not_empty,
    output logic     ovr
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int NW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);
    localparam logic [NW-1:0] FULL_CNT = NW'(DEPTH);

    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [NW-1:0] cnt;
        logic          ovr;
    } ctl_t;

    ctl_t     q, d;
    rx_char_t mem_q [DEPTH];
    logic     cap_full, pop, accept, wr_en;

    always_comb begin
        cap_full = fifo_on ? (q.cnt == FULL_CNT) : (q.cnt != '0);
        pop      = pop_req && (q.cnt != '0);
        accept   = push && (!cap_full || pop);
        wr_en    = accept && !clr;
        d        = q;
        if (clr) begin
            d.wr  = '0;
            d.rd  = '0;
            d.cnt = '0;
        end else begin
            if (accept) d.wr = (q.wr == LAST_PTR) ? '0 : q.wr + 1'b1;
            if (pop)    d.rd = (q.rd == LAST_PTR) ? '0 : q.rd + 1'b1;
            d.cnt = q.cnt + NW'(accept) - NW'(pop);
        end
        if (push && !accept && !clr) d.ovr = 1'b1;
        else if (status_rd)          d.ovr = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                               mem_q[g] <= '0;
            else if (wr_en && q.wr == AW'(g))         mem_q[g] <= wdata;
        end
    end

    assign not_empty = (q.cnt != '0);
    assign head      = not_empty ? mem_q[q.rd] : '0;
    assign ovr       = q.ovr;

    // R6: occupancy never exceeds the queue depth
    a_r6_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= FULL_CNT);

    // R8: a push refused for lack of room raises the overrun flag
    a_r8_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
        (push && cap_full && !pop && !clr) |=> q.ovr);

    // R11: a read of empty storage leaves it empty
    a_r11_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && q.cnt == '0 && !push && !clr) |=> (q.cnt == '0));

    // R10: a clear empties the storage
    a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !not_empty);

    // R7: in single-register mode a full slot stays at one entry
    a_r7_single: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_on && q.cnt == NW'(1) && !pop_req && !clr) |=> (q.cnt == NW'(1)));

endmodule

// File: rtl/sio_rx.sv
module sio_rx
    import sio_rx_pkg::*;
#(
    parameter int DEPTH     = 16,
    parameter int OVS       = 16,
    parameter int SYNC_STGS = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_in,
    input  logic       tick16,
    input  logic [1:0] wlen_sel,
    input  logic       par_en,
    input  logic       par_even,
    input  logic       stop_two,
    input  logic       fifo_on,
    input  logic       rd_strobe,
    input  logic       status_rd,
    input  logic       fifo_clr,
    output logic [7:0] rd_data,
    output logic       rd_perr,
    output logic       rd_ferr,
    output logic       rd_brk,
    output logic       data_rdy,
    output logic       overrun
);
    logic     rx_s;
    logic     push;
    rx_char_t chr;
    rx_char_t head;

    sio_rx_sync #(.STAGES(SYNC_STGS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (rx_in),
        .d_out (rx_s)
    );

    sio_rx_frame #(.OVS(OVS)) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx       (rx_s),
        .tick     (tick16),
        .wlen_sel (wlen_sel),
        .par_en   (par_en),
        .par_even (par_even),
        .stop_two (stop_two),
        .push     (push),
        .chr      (chr)
    );

    sio_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .fifo_on   (fifo_on),
        .push      (push),
        .wdata     (chr),
        .pop_req   (rd_strobe),
        .status_rd (status_rd),
        .clr       (fifo_clr),
        .head      (head),
        .not_empty (data_rdy),
        .ovr       (overrun)
    );

    assign rd_data = head.data;
    assign rd_perr = head.perr;
    assign rd_ferr = head.ferr;
    assign rd_brk  = head.brk;

    // R9: an empty store presents all-zero read outputs
    a_r9_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !data_rdy |-> (rd_data == 8'd0 && !rd_perr && !rd_ferr && !rd_brk));

endmodule

// File: tb/sio_rx_tb.sv
module sio_rx_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_in = 1'b1, tick16 = 1'b0;
    logic [1:0] wlen_sel = 2'b11;
    logic par_en = 1'b0, par_even = 1'b1, stop_two = 1'b0, fifo_on = 1'b0;
    logic rd_strobe = 1'b0, status_rd = 1'b0, fifo_clr = 1'b0;
    logic [7:0] rd_data;
    logic rd_perr, rd_ferr, rd_brk, data_rdy, overrun;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    logic [10:0] exp_q [$];
    bit exp_ovr = 0;

    localparam int BITC = 64;

    always #2 clk = ~clk;

    sio_rx u_dut (.*);

    initial begin : tickgen
        int c = 0;
        forever begin
            @(negedge clk);
            tick16 = (c == 3);
            c = (c + 1) % 4;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] mask_w(input logic [7:0] v, input logic [1:0] w);
        return v & (8'hFF >> (3 - w));
    endfunction

    task automatic hold(input logic v, input int n);
        @(negedge clk);
        rx_in = v;
        repeat (n - 1) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] v, input bit bad_par, input bit bad_stop);
        logic [7:0] dm;
        logic p;
        int cap;
        dm = mask_w(v, wlen_sel);
        p = (^dm) ^ ~par_even;
        if (bad_par) p = ~p;
        hold(1'b0, BITC);
        for (int i = 0; i <= 4 + int'(wlen_sel); i++) hold(dm[i], BITC);
        if (par_en) hold(p, BITC);
        hold(~bad_stop, BITC);
        if (stop_two) hold(1'b1, BITC);
        hold(1'b1, BITC);
        cap = fifo_on ? 16 : 1;
        if (exp_q.size() < cap)
            exp_q.push_back({bad_stop & (dm == 0) & ~(par_en & p), bad_stop,
                             par_en & bad_par, dm});
        else exp_ovr = 1;
    endtask

    task automatic read_one(input string tag);
        logic [10:0] e;
        @(negedge clk);
        if (exp_q.size() == 0) begin
            chk(!data_rdy, {tag, " empty"}, data_rdy, 0);
        end else begin
            e = exp_q.pop_front();
            chk(data_rdy, {tag, " rdy"}, data_rdy, 1);
            chk({rd_brk, rd_ferr, rd_perr, rd_data} == e, tag,
                {rd_brk, rd_ferr, rd_perr, rd_data}, e);
            rd_strobe = 1'b1;
            @(negedge clk);
            rd_strobe = 1'b0;
        end
    endtask

    task automatic pulse_status();
        @(negedge clk);
        status_rd = 1'b1;
        @(negedge clk);
        status_rd = 1'b0;
        exp_ovr = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin : main
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        // R12 reset state
        chk({data_rdy, overrun, rd_data, rd_perr, rd_ferr, rd_brk} == 0, "R12 reset",
            {data_rdy, overrun, rd_data, rd_perr, rd_ferr, rd_brk}, 0);

        // R1 8-bit, R7 single register default
        send(8'hA5, 0, 0);
        read_one("R1 8bit A5");
        wlen_sel = 2'b00;
        send(8'hFF, 0, 0);
        read_one("R1 5bit upper zero");

        // R2 parity both senses and a fault
        wlen_sel = 2'b10; par_en = 1; par_even = 1;
        send(8'h35, 0, 0); read_one("R2 even ok");
        send(8'h35, 1, 0); read_one("R2 even bad");
        par_even = 0;
        send(8'h4C, 0, 0); read_one("R2 odd ok");
        send(8'h4C, 1, 0); read_one("R2 odd bad");
        par_en = 0; wlen_sel = 2'b11;

        // R3 glitch produces nothing
        hold(1'b0, 12);
        hold(1'b1, 3 * BITC);
        read_one("R3 glitch");

        // R4 framing error then recovery, two stop bits
        send(8'h5A, 0, 1); read_one("R4 ferr");
        stop_two = 1;
        send(8'h3C, 0, 0); send(8'hC3, 0, 0);
        read_one("R7 keep first");
        chk(overrun == 1, "R8 overrun hold mode", overrun, 1);
        stop_two = 0;
        @(negedge clk);
        chk(overrun == 1, "R8 sticky", overrun, 1);
        pulse_status();
        chk(overrun == 0, "R8 cleared by status", overrun, 0);

        // R5 long break stores one zero char
        par_en = 1; par_even = 1;
        hold(1'b0, 20 * BITC);
        hold(1'b1, 2 * BITC);
        exp_q.push_back({1'b1, 1'b1, 1'b0, 8'h00});
        read_one("R5 break");
        read_one("R5 single break");
        par_en = 0;

        // R11 read on empty
        @(negedge clk); rd_strobe = 1; @(negedge clk); rd_strobe = 0;
        chk(!data_rdy, "R11 empty read", data_rdy, 0);
        send(8'h11, 0, 0);
        read_one("R11 after empty read");

        // R6 fill queue, overflow by one, R8
        fifo_on = 1;
        for (int i = 0; i < 17; i++) send(8'(i * 13 + 7), 0, 0);
        chk(overrun == 1, "R8 overrun queue", overrun, 1);
        for (int i = 0; i < 16; i++) read_one("R6 order");
        read_one("R6 drained");
        pulse_status();

        // R10 clear
        send(8'h01, 0, 0); send(8'h02, 0, 0);
        @(negedge clk); fifo_clr = 1; @(negedge clk); fifo_clr = 0;
        exp_q.delete();
        chk(!data_rdy && rd_data == 0, "R10 clear", {data_rdy, rd_data}, 0);

        // random mix
        for (int i = 0; i < 48; i++) begin
            wlen_sel = 2'($urandom_range(0, 3));
            par_en = 1'($urandom_range(0, 1));
            par_even = 1'($urandom_range(0, 1));
            stop_two = 1'($urandom_range(0, 1));
            send(8'($urandom), $urandom_range(0, 5) == 0, $urandom_range(0, 6) == 0);
            if ($urandom_range(0, 2) != 0)
                while (exp_q.size() > 0) read_one("R2 R1 R4 random");
        end
        while (exp_q.size() > 0) read_one("R6 random tail");
        chk(overrun == exp_ovr, "R8 random", overrun, exp_ovr);
        finish_run();
    end
endmodule